// File: doc/BRIEF.md
# Four-Bit-Address Accumulator Processor Core

This block is a small 8-bit processor built around one working register. It reads one-byte instructions from a 16-byte memory that sits outside the core. The same memory holds the program and the data it works on. Each instruction carries a 4-bit opcode in its upper nibble and a 4-bit operand in its lower nibble. The operand is a memory address for loads and stores and a shift count for the two shifts. The core holds four architectural registers. The accumulator is the source and destination of every arithmetic result. A second operand register feeds add, subtract and AND. A condition register decides whether the indirect jump is taken. The program counter points at the next instruction.

Every instruction runs through the same three phases, one clock each: fetch, decode, execute. Each phase makes at most one memory access. The memory is expected to answer reads combinationally, and it takes writes on the clock edge that ends the execute phase. A halt instruction parks the core in a frozen state that only reset leaves. The `halted` output shows that state.

Top module: `tacc_core`

## Requirements
- R1: A synchronous reset clears the accumulator, operand register, condition register and program counter to zero. While reset is held, `halted` and `mem_we` are low and `mem_addr` is 0, so the first fetch after reset is from address 0.
- R2: An instruction byte is decoded as opcode = bits [7:4] and operand = bits [3:0]. Every instruction except halt takes exactly three clock cycles. The program counter steps by one per instruction and wraps from 15 to 0.
- R3: Opcode 0x1 loads the byte at the operand address into the accumulator. Opcode 0x5 writes the accumulator to the operand address. During that write `mem_we` is high for exactly one cycle, with `mem_addr` equal to the operand and `mem_wdata` equal to the accumulator.
- R4: Opcode 0x2 copies the accumulator into the operand register, and opcode 0x3 copies it into the condition register.
- R5: Opcode 0x4 loads the program counter from accumulator bits [3:0] when the condition register is nonzero. Otherwise execution continues with the next instruction.
- R6: Opcodes 0x8 (acc+opnd), 0x9 (acc+1), 0xA (acc-opnd) and 0xB (acc-1) write their result to the accumulator modulo 256.
- R7: Opcodes 0xC and 0xD shift the accumulator left and right by the operand count. Vacated bits fill with zero, and a count of 8 or more yields zero.
- R8: Opcode 0xE writes the bitwise AND of the accumulator and the operand register to the accumulator. Opcode 0xF writes the bitwise inverse of the accumulator to it.
- R9: Opcodes 0x6 and 0x7 change no register and no memory. They only advance the program counter.
- R10: Opcode 0x0 raises `halted` at the end of its execute cycle. From then until reset, `halted` stays high, `mem_we` stays low, `mem_addr` does not change and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 4 | Memory address for fetch, load or store |
| mem_rdata | input | 8 | Combinational read data at `mem_addr` |
| mem_wdata | output | 8 | Store data, valid while `mem_we` is high |
| mem_we | output | 1 | Store strobe, write taken at the next rising edge |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
No register can be seen directly at the ports. A corrupted accumulator, operand register or condition register therefore shows up only when a later store writes a wrong byte, or when a conditional jump lands somewhere else. A wrong landing changes which stores happen and how many cycles pass before `halted` rises. A program counter or phase-sequencer fault shows within one instruction, as a fetch address that is out of step or a cycle count to halt that differs from three per executed instruction. Every program is therefore compared against an instruction-level model on three things: the final memory image, the number of store strobes, and the exact cycle on which `halted` rises.

// File: rtl/tacc_pkg.sv
`timescale 1ns/1ps
package tacc_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_HALT  = 4'h0,
      OP_LOAD  = 4'h1,
      OP_MOVB  = 4'h2,
      OP_MOVC  = 4'h3,
      OP_JNZ   = 4'h4,
      OP_STORE = 4'h5,
      OP_RSV6  = 4'h6,
      OP_RSV7  = 4'h7,
      OP_ADD   = 4'h8,
      OP_INC   = 4'h9,
      OP_SUB   = 4'hA,
      OP_DEC   = 4'hB,
      OP_SHL   = 4'hC,
      OP_SHR   = 4'hD,
      OP_AND   = 4'hE,
      OP_NOT   = 4'hF
   } opc_e;

   typedef enum logic [1:0] {
      PH_FETCH  = 2'd0,
      PH_DECODE = 2'd1,
      PH_EXEC   = 2'd2,
      PH_HALT   = 2'd3
   } phase_e;
endpackage

// File: rtl/tacc_alu.sv
`timescale 1ns/1ps
module tacc_alu
   import tacc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  opc_e              op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] res
);
   localparam int STG   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam int USE_W = (CNT_W < STG) ? CNT_W : STG;
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   if (DATA_W < 2) begin : g_bad_width
      $error("tacc_alu: DATA_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("tacc_alu: CNT_W must be at least 1");
   end

   logic [DATA_W-1:0] lsh [USE_W+1];
   logic [DATA_W-1:0] rsh [USE_W+1];
   logic              big;

   assign lsh[0] = a;
   assign rsh[0] = a;

   for (genvar s = 0; s < USE_W; s++) begin : g_stage
      assign lsh[s+1] = cnt[s] ? (lsh[s] << (1 << s)) : lsh[s];
      assign rsh[s+1] = cnt[s] ? (rsh[s] >> (1 << s)) : rsh[s];
   end

   if (CNT_W > STG) begin : g_over
      assign big = |cnt[CNT_W-1:STG];
   end else begin : g_no_over
      assign big = 1'b0;
   end

   always_comb begin
      unique case (op)
         OP_ADD:  res = a + b;
         OP_INC:  res = a + ONE;
         OP_SUB:  res = a - b;
         OP_DEC:  res = a - ONE;
         OP_SHL:  res = big ? '0 : lsh[USE_W];
         OP_SHR:  res = big ? '0 : rsh[USE_W];
         OP_AND:  res = a & b;
         OP_NOT:  res = ~a;
         default: res = a;
      endcase
   end
endmodule

// File: rtl/tacc_seq.sv
`timescale 1ns/1ps
module tacc_seq
   import tacc_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   is_halt,
   output phase_e phase
);
   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_FETCH;
      end else begin
         unique case (phase)
            PH_FETCH:  phase <= PH_DECODE;
            PH_DECODE: phase <= PH_EXEC;
            PH_EXEC:   phase <= is_halt ? PH_HALT : PH_FETCH;
            default:   phase <= PH_HALT;
         endcase
      end
   end

   // R2: the three phases follow one another in a fixed order
   a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
      phase == PH_FETCH |=> phase == PH_DECODE);
   a_r2_decode_then_exec: assert property (@(posedge clk) disable iff (rst)
      phase == PH_DECODE |=> phase == PH_EXEC);
   // R10: only reset leaves the halt state
   a_r10_halt_holds: assert property (@(posedge clk) disable iff (rst)
      phase == PH_HALT |=> phase == PH_HALT);
endmodule

// File: rtl/tacc_core.sv
`timescale 1ns/1ps
module tacc_core
   import tacc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              halted
);
   localparam int OPR_W   = ADDR_W;
   localparam int INSTR_W = OPC_W + OPR_W;

   if (DATA_W != INSTR_W) begin : g_bad_fmt
      $error("tacc_core: DATA_W must equal opcode plus operand width");
   end
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("tacc_core: ADDR_W must not exceed DATA_W");
   end

   logic [DATA_W-1:0] acc, breg, creg, ir, alu_q, alu_res;
   logic [ADDR_W-1:0] pc;
   opc_e              op;
   logic [OPR_W-1:0]  opnd;
   phase_e            phase;
   logic              mem_op;

   assign op   = opc_e'(ir[INSTR_W-1 -: OPC_W]);
   assign opnd = ir[OPR_W-1:0];

   tacc_seq u_seq (
      .clk     (clk),
      .rst     (rst),
      .is_halt (op == OP_HALT),
      .phase   (phase)
   );

   tacc_alu #(.DATA_W(DATA_W), .CNT_W(OPR_W)) u_alu (
      .op  (op),
      .a   (acc),
      .b   (breg),
      .cnt (opnd),
      .res (alu_res)
   );

   assign mem_op    = (phase == PH_EXEC) && ((op == OP_LOAD) || (op == OP_STORE));
   assign mem_addr  = mem_op ? opnd : pc;
   assign mem_we    = (phase == PH_EXEC) && (op == OP_STORE);
   assign mem_wdata = acc;
   assign halted    = (phase == PH_HALT);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc   <= '0;
         breg  <= '0;
         creg  <= '0;
         pc    <= '0;
         ir    <= '0;
         alu_q <= '0;
      end else begin
         unique case (phase)
            PH_FETCH: begin
               ir <= mem_rdata;
               pc <= pc + 1'b1;
            end
            PH_DECODE: alu_q <= alu_res;
            PH_EXEC: begin
               unique case (op)
                  OP_LOAD: acc  <= mem_rdata;
                  OP_MOVB: breg <= acc;
                  OP_MOVC: creg <= acc;
                  OP_JNZ:  if (creg != '0) pc <= acc[ADDR_W-1:0];
                  OP_ADD, OP_INC, OP_SUB, OP_DEC,
                  OP_SHL, OP_SHR, OP_AND, OP_NOT: acc <= alu_q;
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end

   // R2: fetch advances the program counter by one, wrapping
   a_r2_pc_advance: assert property (@(posedge clk) disable iff (rst)
      phase == PH_FETCH |=> pc == $past(pc) + 1'b1);
   // R3: a store strobe lasts a single cycle
   a_r3_store_pulse: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we);
   // R4: copy into the operand register takes the accumulator
   a_r4_copy_b: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC && op == OP_MOVB) |=> breg == $past(acc));
   // R5: taken jump lands on the low accumulator bits
   a_r5_jump_taken: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC && op == OP_JNZ && creg != '0) |=> pc == $past(acc[ADDR_W-1:0]));
   // R5: untaken jump leaves the program counter alone
   a_r5_jump_not_taken: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC && op == OP_JNZ && creg == '0) |=> $stable(pc));
   // R9: reserved opcodes touch no register
   a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC && (op == OP_RSV6 || op == OP_RSV7))
      |=> ($stable(acc) && $stable(breg) && $stable(creg)));
   // R10: halted core never writes
   a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
      halted |-> !mem_we);
   // R10: halted core holds its state and address
   a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
      halted |=> ($stable(acc) && $stable(pc) && $stable(creg) && $stable(mem_addr)));
endmodule

// File: tb/tacc_core_tb.sv
`timescale 1ns/1ps
module tacc_core_tb;
   typedef logic [7:0] img_t [16];

   logic       clk = 1'b0;
   logic       rst;
   logic [3:0] mem_addr;
   logic [7:0] mem_rdata, mem_wdata;
   logic       mem_we, halted;
   logic [7:0] mem [16];
   int         n_chk = 0;
   int         n_fail = 0;

   always #5 clk = ~clk;

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

   tacc_core u_dut (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Instruction-level model: returns final image, instructions run, stores
   task automatic model(input img_t img, output img_t m, output int ninst, output int nst);
      logic [7:0] a = 0, b = 0, c = 0, ins;
      logic [3:0] pc = 0, x;
      bit         done = 0;
      m = img; ninst = 0; nst = 0;
      for (int k = 0; k < 1000 && !done; k++) begin
         ins = m[pc]; x = ins[3:0];
         pc = 4'(pc + 1); ninst++;
         case (ins[7:4])
            4'h0: done = 1;
            4'h1: a = m[x];
            4'h2: b = a;
            4'h3: c = a;
            4'h4: if (c != 0) pc = a[3:0];
            4'h5: begin m[x] = a; nst++; end
            4'h8: a = 8'(a + b);
            4'h9: a = 8'(a + 8'd1);
            4'hA: a = 8'(a - b);
            4'hB: a = 8'(a - 8'd1);
            4'hC: a = (x >= 4'd8) ? 8'h00 : 8'(a << x);
            4'hD: a = (x >= 4'd8) ? 8'h00 : 8'(a >> x);
            4'hE: a = a & b;
            4'hF: a = ~a;
            default: ;
         endcase
      end
      if (!done) ninst = -1;
   endtask

   task automatic run_prog(input string req, input img_t prog);
      img_t exp;
      int   ni, ns, cyc, we_seen, bad, bad_a;
      model(prog, exp, ni, ns);
      rst = 1'b1;
      mem = prog;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      cyc = 0; we_seen = 0;
      do begin
         @(negedge clk);
         cyc++;
         if (mem_we) we_seen++;
      end while (!halted && cyc < 2000);
      // R2 / R10: halted rises exactly three cycles per executed instruction
      check(cyc == 3 * ni, {req, " R2 R10"}, "cycles to halt", cyc, 3 * ni);
      // R3: number of store strobes
      check(we_seen == ns, {req, " R3"}, "store count", we_seen, ns);
      bad = 0; bad_a = 0;
      for (int i = 15; i >= 0; i--) if (mem[i] !== exp[i]) begin bad++; bad_a = i; end
      check(bad == 0, req, $sformatf("memory byte %0d", bad_a), mem[bad_a], exp[bad_a]);
   endtask

   // R6: add/sub/inc/dec with wrap in both directions
   task automatic t_arith();
      img_t p = '{default: 8'h00};
      p[0] = 8'h1E; p[1] = 8'h20; p[2] = 8'h80; p[3] = 8'hA0; p[4] = 8'h5D;
      p[5] = 8'h1F; p[6] = 8'h90; p[7] = 8'hB0; p[8] = 8'hB0; p[9] = 8'h5C;
      p[14] = 8'hF0; p[15] = 8'hFF;
      run_prog("R6", p);
   endtask

   // R7: shifts by 3, 2, 8 and 15
   task automatic t_shift();
      img_t p = '{default: 8'h00};
      p[0] = 8'h1F; p[1] = 8'hC3; p[2] = 8'h5E; p[3] = 8'h1F; p[4] = 8'hD2;
      p[5] = 8'h5D; p[6] = 8'h1F; p[7] = 8'hC8; p[8] = 8'h5C; p[9] = 8'h1F;
      p[10] = 8'hDF; p[11] = 8'h5B; p[15] = 8'h96;
      run_prog("R7", p);
   endtask

   // R4 and R8: copy to operand register, AND, NOT
   task automatic t_logic();
      img_t p = '{default: 8'h00};
      p[0] = 8'h1F; p[1] = 8'h20; p[2] = 8'h1E; p[3] = 8'hE0; p[4] = 8'h5D;
      p[5] = 8'hF0; p[6] = 8'h5C; p[14] = 8'hF5; p[15] = 8'h3C;
      run_prog("R4 R8", p);
   endtask

   // R9: reserved opcodes with several operands leave the accumulator intact
   task automatic t_nop();
      img_t p = '{default: 8'h00};
      p[0] = 8'h1F; p[1] = 8'h60; p[2] = 8'h7F; p[3] = 8'h65; p[4] = 8'h5E;
      p[15] = 8'h42;
      run_prog("R9", p);
   endtask

   // R5: untaken jump with condition zero, then taken jump to address 9
   task automatic t_jump();
      img_t p = '{default: 8'h00};
      p[0] = 8'h1F; p[1] = 8'h40; p[2] = 8'h5E; p[3] = 8'h30; p[4] = 8'h40;
      p[5] = 8'h5D; p[9] = 8'hF0; p[10] = 8'h5C; p[15] = 8'h09;
      run_prog("R5", p);
   endtask

   // R1: registers left nonzero by the previous program must read back zero
   task automatic t_reset_clear();
      img_t p = '{default: 8'h00};
      p[0] = 8'h5D; p[1] = 8'h80; p[2] = 8'h5E; p[3] = 8'hF0; p[4] = 8'h40;
      p[5] = 8'h5C;
      run_prog("R1", p);
   endtask

   // R2: program runs off address 15, wraps and hits a halt it wrote at 0
   task automatic t_wrap();
      img_t p = '{default: 8'h60};
      p[0] = 8'h1F; p[1] = 8'h20; p[2] = 8'hF0; p[3] = 8'hE0; p[4] = 8'h50;
      run_prog("R2", p);
   endtask

   // R10 then R1: frozen while halted, released by reset
   task automatic t_halt_freeze();
      logic [3:0] a0 = mem_addr;
      int moved = 0, drop = 0, wr = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (mem_addr !== a0) moved++;
         if (!halted) drop++;
         if (mem_we) wr++;
      end
      check(drop == 0, "R10", "halted low cycles", drop, 0);
      check(moved == 0, "R10", "address changes", moved, 0);
      check(wr == 0, "R10", "writes while halted", wr, 0);
      rst = 1'b1;
      @(negedge clk);
      check(halted == 1'b0, "R1", "halted after reset", halted, 0);
      check(mem_addr == 4'd0, "R1", "address after reset", mem_addr, 0);
      rst = 1'b0;
   endtask

   initial begin
      rst = 1'b1;
      mem = '{default: 8'h00};
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      check(halted == 1'b0, "R1", "halted in reset", halted, 0);
      check(mem_we == 1'b0, "R1", "write strobe in reset", mem_we, 0);
      check(mem_addr == 4'd0, "R1", "address in reset", mem_addr, 0);
      t_arith();
      t_shift();
      t_logic();
      t_nop();
      t_jump();
      t_reset_clear();
      t_wrap();
      t_halt_freeze();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule